// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a watchdog countdown timer that software sets up through three byte-wide registers. Writing a non-zero time-out value to the count register loads the down-counter and starts it. A prescaler divides the system clock into count ticks. A tick can be one second or one minute long, and either unit can be made 1000 times shorter. When the count runs out, an active-low time-out output falls and stays low until software writes the count register again. The same event can also drive a low pulse of fixed length onto a keyboard-reset output.

Keyboard and mouse interrupt lines can each reload the last non-zero time-out value, so normal input activity keeps the timer from expiring. A rising edge on an external reset input can force an immediate time-out. The host port is a plain register interface: a write strobe, an address, write data and combinational read data. The interrupt and reset inputs are taken to be synchronous to `clk`.

Top module: `wdt_core`

## Requirements
- R1: After reset, all three registers read 00h, and `wdto_n` and `kbrst_n` are both high.
- R2: Address 0 is the mode register. Bit 1 enables the keyboard-reset pulse, bit 2 enables the external-reset time-out, bit 3 selects minutes (0 = seconds) and bit 4 makes ticks 1000 times shorter. Bits 7..5 and bit 0 are not stored and read as 0.
- R3: A write of a non-zero value N to address 1 (the count register) starts a countdown. `wdto_n` falls exactly N×P clock edges after the write edge. P is CLK_HZ for seconds, 60·CLK_HZ for minutes, and CLK_HZ/1000 or 60·CLK_HZ/1000 when bit 4 is set.
- R4: Reading address 1 returns the live count, which drops by one on each tick.
- R5: Writing 00h to address 1 stops the count at 0. No time-out follows, and `wdto_n` is driven high.
- R6: After a time-out, `wdto_n` stays low until address 1 is written. Interrupt reloads do not release it.
- R7: Address 2 bit 0 is a time-out flag. Each time-out sets it. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: Address 2 bit 7 enables reload on a mouse-interrupt rising edge, and bit 6 enables reload on a keyboard-interrupt rising edge. Each bit acts alone. A reload loads the last non-zero value written to address 1 and restarts the prescaler.
- R9: Several actions can fall on the same edge. A host write to address 1 takes precedence over an external forced time-out, that forced time-out over an interrupt reload, and an interrupt reload over a tick. A reload on the expiring edge therefore prevents the time-out.
- R10: With mode bit 2 set, a rising edge on `ext_rst_in` forces a time-out and clears the count. With bit 2 clear, the edge has no effect.
- R11: If mode bit 1 is set when a time-out occurs, `kbrst_n` goes low for exactly PULSE_CYC cycles, starting at the time-out edge. Otherwise `kbrst_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 2 | Register address for read and write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| kbd_irq | input | 1 | Keyboard interrupt, rising edge can reload |
| mouse_irq | input | 1 | Mouse interrupt, rising edge can reload |
| ext_rst_in | input | 1 | External reset, rising edge can force time-out |
| wdto_n | output | 1 | Active-low latched time-out |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The sharpest case is an interrupt reload landing on the same edge as the final tick. The bench loads a short count in millisecond mode, counts clock edges to the expiry edge, and raises the mouse interrupt in the cycle before it. The check passes when `wdto_n` stays high, the count reads the reloaded value, and the time-out then arrives one full period later. A second case raises an interrupt in the cycle of a host count write. The check passes when the written value, not the stored reload value, is read back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    A_MODE  = 2'd0,
    A_COUNT = 2'd1,
    A_EVENT = 2'd2,
    A_SPARE = 2'd3
  } wdt_addr_e;

  // mode register bit positions
  localparam int MB_KBRST  = 1;
  localparam int MB_EXTRST = 2;
  localparam int MB_MINUTE = 3;
  localparam int MB_FAST   = 4;
  localparam logic [DW-1:0] MODE_MASK = 8'h1E;

  // event register bit positions
  localparam int EB_MOUSE = 7;
  localparam int EB_KBD   = 6;
  localparam int EB_FLAG  = 0;
endpackage

// File: rtl/wdt_edge_det.sv
module wdt_edge_det #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise[i] = sig[i] & ~prev_q[i];
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int CLK_HZ = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic minute,
  input  logic fast,
  output logic tick
);
  localparam int P_SEC  = CLK_HZ;
  localparam int P_MIN  = 60 * CLK_HZ;
  localparam int P_FSEC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int P_FMIN = (60 * CLK_HZ / 1000 < 1) ? 1 : 60 * CLK_HZ / 1000;
  localparam int PW     = $clog2(P_MIN + 1);

  logic [PW-1:0] presc_q;
  logic [PW-1:0] period;

  always_comb begin
    unique case ({minute, fast})
      2'b00:   period = PW'(P_SEC);
      2'b01:   period = PW'(P_FSEC);
      2'b10:   period = PW'(P_MIN);
      default: period = PW'(P_FMIN);
    endcase
  end

  assign tick = run && !restart && (presc_q >= period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                presc_q <= '0;
    else if (restart || !run)  presc_q <= '0;
    else if (tick)             presc_q <= '0;
    else                       presc_q <= presc_q + 1'b1;
  end

  // R3
  presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && presc_q < period) |=> (presc_q <= period));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          reload,
  input  logic          force_to,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          restart,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rval_q;
  logic          reload_ok;

  assign reload_ok = reload && (rval_q != '0);
  assign restart   = load || force_to || reload_ok;

  always_comb begin
    if (load)           expire = 1'b0;
    else if (force_to)  expire = 1'b1;
    else if (reload_ok) expire = 1'b0;
    else                expire = tick && (cnt_q == CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rval_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      if (load_val != '0) rval_q <= load_val;
    end else if (force_to) begin
      cnt_q <= '0;
    end else if (reload_ok) begin
      cnt_q <= rval_q;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !force_to && !reload_ok) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) - 1'b1)));

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load && !reload_ok) |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_n
);
  localparam int PCW = $clog2(PULSE_CYC + 1);

  logic [PCW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt_q <= '0;
    else if (start)          pcnt_q <= PCW'(PULSE_CYC);
    else if (pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
  end

  assign pulse_n = (pcnt_q == '0);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CLK_HZ    = 2000,
  parameter int PULSE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          kbd_irq,
  input  logic          mouse_irq,
  input  logic          ext_rst_in,
  output logic          wdto_n,
  output logic          kbrst_n
);
  logic [DW-1:0] mode_q;
  logic          mouse_en_q, kbd_en_q, flag_q, wdto_q;
  logic          wr_mode, wr_cnt, wr_evt;
  logic [2:0]    rise;
  logic          reload, force_to, tick, restart, expire;
  logic [DW-1:0] cnt;

  assign wr_mode = host_wr && (host_addr == A_MODE);
  assign wr_cnt  = host_wr && (host_addr == A_COUNT);
  assign wr_evt  = host_wr && (host_addr == A_EVENT);

  wdt_edge_det #(.W(3)) edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({ext_rst_in, mouse_irq, kbd_irq}),
    .rise (rise)
  );

  assign reload   = (rise[1] && mouse_en_q) || (rise[0] && kbd_en_q);
  assign force_to = rise[2] && mode_q[MB_EXTRST];

  wdt_prescaler #(.CLK_HZ(CLK_HZ)) presc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cnt != '0),
    .restart(restart),
    .minute (mode_q[MB_MINUTE]),
    .fast   (mode_q[MB_FAST]),
    .tick   (tick)
  );

  wdt_countdown #(.CW(DW)) cd_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_cnt),
    .load_val(host_wdata),
    .reload  (reload),
    .force_to(force_to),
    .tick    (tick),
    .cnt     (cnt),
    .restart (restart),
    .expire  (expire)
  );

  wdt_pulse #(.PULSE_CYC(PULSE_CYC)) pulse_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (expire && mode_q[MB_KBRST]),
    .pulse_n(kbrst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      mouse_en_q <= 1'b0;
      kbd_en_q   <= 1'b0;
      flag_q     <= 1'b0;
      wdto_q     <= 1'b1;
    end else begin
      if (wr_mode) mode_q <= host_wdata & MODE_MASK;
      if (wr_evt) begin
        mouse_en_q <= host_wdata[EB_MOUSE];
        kbd_en_q   <= host_wdata[EB_KBD];
      end
      if (expire)                            flag_q <= 1'b1;
      else if (wr_evt && host_wdata[EB_FLAG]) flag_q <= 1'b0;
      if (wr_cnt)      wdto_q <= 1'b1;
      else if (expire) wdto_q <= 1'b0;
    end
  end

  assign wdto_n = wdto_q;

  always_comb begin
    unique case (host_addr)
      A_MODE:  host_rdata = mode_q;
      A_COUNT: host_rdata = cnt;
      A_EVENT: host_rdata = {mouse_en_q, kbd_en_q, 5'b0, flag_q};
      default: host_rdata = '0;
    endcase
  end

  // R7
  flag_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdto_n) |-> flag_q);

  // R6
  release_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdto_n) |-> $past(host_wr && host_addr == A_COUNT));

  // R11
  kbrst_with_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kbrst_n) |-> !wdto_n);
endmodule

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       kbd_irq = 1'b0, mouse_irq = 1'b0, ext_rst_in = 1'b0;
  logic       wdto_n, kbrst_n;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_core #(.CLK_HZ(2000), .PULSE_CYC(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .kbd_irq(kbd_irq),
    .mouse_irq(mouse_irq), .ext_rst_in(ext_rst_in), .wdto_n(wdto_n),
    .kbrst_n(kbrst_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 wdto_n", wdto_n, 1);
    check("R1 kbrst_n", kbrst_n, 1);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      check("R1 reg", d, 0);
    end
  endtask

  task automatic t_mode();
    logic [7:0] d;
    wr(0, 8'hFF); rd(0, d); check("R2 mask", d, 8'h1E);
    wr(0, 8'h00); rd(0, d); check("R2 clear", d, 0);
  endtask

  task automatic t_fast_sec();
    logic [7:0] d;
    wr(0, 8'h10);
    wr(1, 8'd5);
    edges(9);  check("R3 early", wdto_n, 1);
    edges(1);  check("R3 expiry", wdto_n, 0);
    rd(2, d);  check("R7 set", d[0], 1);
    edges(5);  check("R6 held", wdto_n, 0);
    rd(1, d);  check("R5 count zero", d, 0);
    wr(2, 8'h00); rd(2, d); check("R7 write0 keeps", d[0], 1);
    wr(2, 8'h01); rd(2, d); check("R7 clear", d[0], 0);
    wr(1, 8'h00); check("R6 release", wdto_n, 1);
  endtask

  task automatic t_live_disable();
    logic [7:0] d;
    wr(1, 8'd5);
    edges(4); rd(1, d); check("R4 live", d, 3);
    wr(1, 8'd0);
    edges(20); rd(1, d); check("R5 stopped", d, 0);
    check("R5 no timeout", wdto_n, 1);
  endtask

  task automatic t_milli_min();
    wr(0, 8'h18);
    wr(1, 8'd2);
    edges(239); check("R3 mmin early", wdto_n, 1);
    edges(1);   check("R3 mmin expiry", wdto_n, 0);
    wr(1, 8'd0);
  endtask

  task automatic t_second();
    wr(0, 8'h00);
    wr(1, 8'd1);
    edges(1999); check("R3 sec early", wdto_n, 1);
    edges(1);    check("R3 sec expiry", wdto_n, 0);
    wr(1, 8'd0);
  endtask

  task automatic t_reload();
    logic [7:0] d;
    wr(0, 8'h10);
    wr(2, 8'h80);
    wr(1, 8'd4);
    edges(4);
    kbd_irq = 1'b1; edges(1); kbd_irq = 1'b0;
    rd(1, d); check("R8 kbd disabled", d, 2);
    mouse_irq = 1'b1; edges(1); mouse_irq = 1'b0;
    rd(1, d); check("R8 mouse reload", d, 4);
    edges(7); check("R8 restart early", wdto_n, 1);
    edges(1); check("R8 restart expiry", wdto_n, 0);
    mouse_irq = 1'b1; edges(1); mouse_irq = 1'b0;
    check("R6 reload keeps low", wdto_n, 0);
    wr(1, 8'd0);
    wr(2, 8'h40);
    wr(1, 8'd4);
    edges(4);
    mouse_irq = 1'b1; edges(1); mouse_irq = 1'b0;
    rd(1, d); check("R8 mouse disabled", d, 2);
    kbd_irq = 1'b1; edges(1); kbd_irq = 1'b0;
    rd(1, d); check("R8 kbd reload", d, 4);
    wr(1, 8'd0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(0, 8'h10);
    wr(2, 8'hC0);
    wr(1, 8'd3);
    edges(5);
    mouse_irq = 1'b1; edges(1); mouse_irq = 1'b0;
    check("R9 reload beats expiry", wdto_n, 1);
    rd(1, d); check("R9 reloaded", d, 3);
    edges(5); check("R9 late early", wdto_n, 1);
    edges(1); check("R9 late expiry", wdto_n, 0);
    wr(1, 8'd0);
    mouse_irq = 1'b1;
    wr(1, 8'd7);
    mouse_irq = 1'b0;
    rd(1, d); check("R9 write beats reload", d, 7);
    wr(1, 8'd0);
    wr(2, 8'h01);
  endtask

  task automatic t_force();
    logic [7:0] d;
    wr(0, 8'h10);
    wr(1, 8'd5);
    edges(1);
    ext_rst_in = 1'b1; edges(1); ext_rst_in = 1'b0;
    check("R10 disabled no timeout", wdto_n, 1);
    rd(1, d); check("R10 disabled count", d, 4);
    wr(0, 8'h14);
    ext_rst_in = 1'b1; edges(1); ext_rst_in = 1'b0;
    check("R10 forced", wdto_n, 0);
    rd(1, d); check("R10 count cleared", d, 0);
    rd(2, d); check("R10 flag", d[0], 1);
    wr(2, 8'h01);
    wr(1, 8'd0);
  endtask

  task automatic t_kbrst();
    wr(0, 8'h12);
    wr(1, 8'd1);
    edges(2);  check("R11 to", wdto_n, 0);
    check("R11 pulse start", kbrst_n, 0);
    edges(15); check("R11 pulse last", kbrst_n, 0);
    edges(1);  check("R11 pulse end", kbrst_n, 1);
    wr(1, 8'd0);
    wr(0, 8'h10);
    wr(1, 8'd1);
    edges(2);  check("R11 off to", wdto_n, 0);
    check("R11 no pulse", kbrst_n, 1);
    wr(1, 8'd0);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_mode();
    t_fast_sec();
    t_live_disable();
    t_milli_min();
    t_second();
    t_reload();
    t_collision();
    t_force();
    t_kbrst();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule